// File: doc/BRIEF.md
# Multiply/Divide Unit with Busy Interlock

This block performs 32-bit signed and unsigned multiplication and division and writes the outcome into a pair of result registers, HI and LO. An operation is issued with an opcode and two operands. Its result lands in HI/LO at the issuing clock edge. Alongside the result, the unit stores a time stamp. The stamp is the value of an external free-running cycle counter at which the operation would finish. The finish time depends on the operation and, for multiplies, on the magnitude of the first operand.

A consumer reads HI or LO through a read port that names a destination register. The unit compares the stored stamp against the current counter with wrap-around arithmetic. If the operation is judged still in flight, it raises a stall output, and the requester holds its request until the stall drops. A configuration input disables the interlock. In that mode no stamp is recorded and reads never stall. Only one operation is tracked at a time; a new issue replaces the stamp.

Top module: `muldiv_interlock`

## Requirements
- R1: `issue_op` encoding is 0 = signed multiply, 1 = unsigned multiply, 2 = signed divide, 3 = unsigned divide. Unsigned multiply places bits 63..32 of the 64-bit unsigned product in HI and bits 31..0 in LO.
- R2: Signed multiply places the upper and lower halves of the 64-bit two's-complement product in HI and LO.
- R3: Divide with a non-zero divisor writes the quotient to LO and the remainder to HI. The signed quotient truncates toward zero, and the signed remainder takes the dividend's sign.
- R4: Division by zero does not trap and leaves HI equal to the dividend. LO becomes 0xFFFFFFFF for unsigned divide. For signed divide, LO becomes 0xFFFFFFFF when the dividend is non-negative and 0x00000001 when it is negative.
- R5: Signed divide of 0x80000000 by 0xFFFFFFFF gives LO = 0x80000000 and HI = 0.
- R6: A read issued in the cycle after an operation returns that operation's result; a read in the same cycle as an issue returns the previous contents.
- R7: Unsigned multiply latency is 7 cycles when rs has at most 10 significant bits. It is 11 cycles for 11 to 21 significant bits and 15 cycles for 22 or more. Zero counts as one significant bit.
- R8: Signed multiply latency uses the same bands, applied to rs XOR (rs arithmetic-shifted right by 21).
- R9: Both divides have a latency of 37 cycles.
- R10: An issue at counter value T records T + latency modulo 2^32. A read stalls exactly when (stamp − counter) mod 2^32 lies in 1..37. A remaining distance of 0 or more than 37 lets the read proceed in the same cycle.
- R11: A read that names destination 0 never asserts `wr_en`, but it stalls under the same rule as any other read.
- R12: While `cfg_no_interlock` is 1, `stall` stays 0 and an issue leaves the stamp unchanged.
- R13: After reset, HI, LO and the stamp are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_no_interlock | input | 1 | 1 disables latency tracking and stalls |
| cycle_now | input | 32 | Free-running cycle counter value |
| issue_valid | input | 1 | Start an operation this cycle |
| issue_op | input | 2 | Operation code (see R1) |
| issue_rs | input | 32 | First operand / dividend |
| issue_rt | input | 32 | Second operand / divisor |
| rd_req | input | 1 | Request to read HI or LO |
| rd_sel_hi | input | 1 | 1 selects HI, 0 selects LO |
| rd_dest | input | 5 | Destination register index of the read |
| stall | output | 1 | Read must be held this cycle |
| wr_en | output | 1 | Read completes and writes the destination |
| wr_dest | output | 5 | Destination register index for the write |
| wr_data | output | 32 | HI or LO value being returned |

## Verification
Multiply operands are placed on both sides of each significant-bit band boundary (10/11 and 21/22 bits), and signed operands are chosen so that the XOR with the shifted sign gives a different band from the raw value. This separates the two latency formulas from each other and from an off-by-one band. Divides cover truncation with mixed signs, zero divisors of both dividend signs, and the single overflowing case. The stall window is tested with a stamp that wraps past 2^32 and with the counter moved so the distance is exactly 37, exactly 38, or beyond the stamp. These cases separate a wrap-aware compare from a plain magnitude compare and locate the window edge. Disabled-interlock runs show the result is visible one cycle after issue and that no stamp is left behind when the interlock is turned back on.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        OP_MULT  = 2'd0,
        OP_MULTU = 2'd1,
        OP_DIV   = 2'd2,
        OP_DIVU  = 2'd3
    } mdu_op_e;

    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } hilo_t;

    function automatic logic op_is_div(mdu_op_e op);
        return (op == OP_DIV) || (op == OP_DIVU);
    endfunction

    function automatic logic [WORD_W-1:0] negate_if(logic neg, logic [WORD_W-1:0] v);
        return neg ? (WORD_W'(0) - v) : v;
    endfunction

endpackage

// File: rtl/mdu_latency.sv
module mdu_latency
    import mdu_pkg::*;
#(
    parameter int W          = WORD_W,
    parameter int MUL_BASE   = 7,
    parameter int MUL_STEP   = 4,
    parameter int LZ_BAND    = 11,
    parameter int SIGN_SHIFT = 21,
    parameter int DIV_LAT    = 37,
    parameter int LAT_W      = 6
) (
    input  mdu_op_e          op,
    input  logic [W-1:0]     rs,
    output logic [LAT_W-1:0] lat
);
    localparam int LZ_W  = $clog2(W) + 1;
    localparam int BANDS = (W - 1) / LZ_BAND;

    logic [W-1:0]    probe;
    logic [LZ_W-1:0] lz;
    int              mul_cycles;

    // Signed multiply measures the distance from a pure sign extension.
    always_comb begin
        if (op == OP_MULT) begin
            probe = (rs ^ W'($signed(rs) >>> SIGN_SHIFT)) | W'(1);
        end else begin
            probe = rs | W'(1);
        end
    end

    // Leading-zero count: the highest set bit wins.
    always_comb begin
        lz = LZ_W'(W - 1);
        for (int i = 0; i < W; i++) begin
            if (probe[i]) lz = LZ_W'(W - 1 - i);
        end
    end

    always_comb begin
        mul_cycles = MUL_BASE + (BANDS - (int'(lz) / LZ_BAND)) * MUL_STEP;
        if (op_is_div(op)) begin
            lat = LAT_W'(DIV_LAT);
        end else begin
            lat = LAT_W'(mul_cycles);
        end
    end

endmodule

// File: rtl/mdu_arith.sv
module mdu_arith
    import mdu_pkg::*;
(
    input  mdu_op_e           op,
    input  logic [WORD_W-1:0] rs,
    input  logic [WORD_W-1:0] rt,
    output hilo_t             res
);
    localparam int W  = WORD_W;
    localparam int PW = 2 * W;

    logic [PW-1:0] prod_u;
    logic [PW-1:0] prod_s;
    logic          signed_div;
    logic          neg_num;
    logic          neg_den;
    logic [W-1:0]  num;
    logic [W-1:0]  den;
    logic [W-1:0]  quo;
    logic [W-1:0]  rem;
    logic          den_zero;

    // Sign extension to 2W bits makes the low 2W bits of the product exact.
    assign prod_u = {{W{1'b0}}, rs} * {{W{1'b0}}, rt};
    assign prod_s = {{W{rs[W-1]}}, rs} * {{W{rt[W-1]}}, rt};

    // One unsigned divider serves both divides; signed operands enter as magnitudes.
    assign signed_div = (op == OP_DIV);
    assign neg_num    = signed_div && rs[W-1];
    assign neg_den    = signed_div && rt[W-1];
    assign num        = negate_if(neg_num, rs);
    assign den        = negate_if(neg_den, rt);
    assign den_zero   = (rt == '0);

    always_comb begin
        if (den_zero) begin
            quo = '0;
            rem = '0;
        end else begin
            quo = num / den;
            rem = num % den;
        end
    end

    always_comb begin
        unique case (op)
            OP_MULT:  res = '{hi: prod_s[PW-1:W], lo: prod_s[W-1:0]};
            OP_MULTU: res = '{hi: prod_u[PW-1:W], lo: prod_u[W-1:0]};
            OP_DIV: begin
                if (den_zero) begin
                    res = '{hi: rs, lo: (rs[W-1] ? W'(1) : {W{1'b1}})};
                end else begin
                    res = '{hi: negate_if(neg_num, rem),
                            lo: negate_if(neg_num ^ neg_den, quo)};
                end
            end
            default: begin
                if (den_zero) begin
                    res = '{hi: rs, lo: {W{1'b1}}};
                end else begin
                    res = '{hi: rem, lo: quo};
                end
            end
        endcase
    end

endmodule

// File: rtl/mdu_interlock.sv
module mdu_interlock #(
    parameter int W            = 32,
    parameter int LAT_W        = 6,
    parameter int STALL_WINDOW = 37
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             no_interlock,
    input  logic [W-1:0]     now,
    input  logic             issue_valid,
    input  logic [LAT_W-1:0] lat,
    input  logic             rd_req,
    output logic             stall
);
    logic [W-1:0] busy_until;
    logic [W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_until <= '0;
        end else if (issue_valid && !no_interlock) begin
            busy_until <= now + W'(lat);
        end
    end

    // Modulo-2^W distance; a stamp behind the counter looks far away.
    assign left  = busy_until - now;
    assign stall = rd_req && !no_interlock && (left != '0) && (left <= W'(STALL_WINDOW));

    p_stall_only_on_read_r10: assert property (@(posedge clk) disable iff (rst)
        stall |-> rd_req);

    p_no_stall_when_off_r12: assert property (@(posedge clk) disable iff (rst)
        no_interlock |-> !stall);

    p_stamp_in_window_r9: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !no_interlock) |=>
            ((busy_until - $past(now)) >= W'(1)) &&
            ((busy_until - $past(now)) <= W'(STALL_WINDOW)));

    p_stamp_held_when_off_r12: assert property (@(posedge clk) disable iff (rst)
        (no_interlock && !$isunknown(busy_until)) |=> $stable(busy_until));

endmodule

// File: rtl/muldiv_interlock.sv
module muldiv_interlock
    import mdu_pkg::*;
#(
    parameter int MUL_BASE     = 7,
    parameter int MUL_STEP     = 4,
    parameter int LZ_BAND      = 11,
    parameter int SIGN_SHIFT   = 21,
    parameter int DIV_LAT      = 37,
    parameter int STALL_WINDOW = 37,
    parameter int REG_IDX_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_no_interlock,
    input  logic [WORD_W-1:0]    cycle_now,
    input  logic                 issue_valid,
    input  logic [1:0]           issue_op,
    input  logic [WORD_W-1:0]    issue_rs,
    input  logic [WORD_W-1:0]    issue_rt,
    input  logic                 rd_req,
    input  logic                 rd_sel_hi,
    input  logic [REG_IDX_W-1:0] rd_dest,
    output logic                 stall,
    output logic                 wr_en,
    output logic [REG_IDX_W-1:0] wr_dest,
    output logic [WORD_W-1:0]    wr_data
);
    localparam int BANDS = (WORD_W - 1) / LZ_BAND;
    localparam int LAT_W = $clog2(DIV_LAT + MUL_BASE + BANDS * MUL_STEP + 1);

    mdu_op_e          op;
    hilo_t            result;
    hilo_t            hilo_q;
    logic [LAT_W-1:0] lat;

    assign op = mdu_op_e'(issue_op);

    mdu_arith u_arith (
        .op  (op),
        .rs  (issue_rs),
        .rt  (issue_rt),
        .res (result)
    );

    mdu_latency #(
        .W          (WORD_W),
        .MUL_BASE   (MUL_BASE),
        .MUL_STEP   (MUL_STEP),
        .LZ_BAND    (LZ_BAND),
        .SIGN_SHIFT (SIGN_SHIFT),
        .DIV_LAT    (DIV_LAT),
        .LAT_W      (LAT_W)
    ) u_latency (
        .op  (op),
        .rs  (issue_rs),
        .lat (lat)
    );

    mdu_interlock #(
        .W            (WORD_W),
        .LAT_W        (LAT_W),
        .STALL_WINDOW (STALL_WINDOW)
    ) u_interlock (
        .clk          (clk),
        .rst          (rst),
        .no_interlock (cfg_no_interlock),
        .now          (cycle_now),
        .issue_valid  (issue_valid),
        .lat          (lat),
        .rd_req       (rd_req),
        .stall        (stall)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hilo_q <= '0;
        end else if (issue_valid) begin
            hilo_q <= result;
        end
    end

    assign wr_en   = rd_req && !stall && (rd_dest != '0);
    assign wr_dest = rd_dest;
    assign wr_data = rd_sel_hi ? hilo_q.hi : hilo_q.lo;

    p_write_not_zero_r11: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_dest != '0));

    p_divu_identity_r3: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_op == 2'd3 && issue_rt != '0) |=>
            ((hilo_q.lo * $past(issue_rt) + hilo_q.hi) == $past(issue_rs)) &&
            (hilo_q.hi < $past(issue_rt)));

    p_divu_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_op == 2'd3 && issue_rt == '0) |=>
            (hilo_q.lo == '1) && (hilo_q.hi == $past(issue_rs)));

endmodule

// File: tb/muldiv_interlock_tb_top.sv
module muldiv_interlock_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_no_interlock;
    logic [31:0] cycle_now;
    logic        issue_valid;
    logic [1:0]  issue_op;
    logic [31:0] issue_rs;
    logic [31:0] issue_rt;
    logic        rd_req;
    logic        rd_sel_hi;
    logic [4:0]  rd_dest;
    logic        stall;
    logic        wr_en;
    logic [4:0]  wr_dest;
    logic [31:0] wr_data;

    always #4 clk = ~clk;

    muldiv_interlock dut_i (
        .clk              (clk),
        .rst              (rst),
        .cfg_no_interlock (cfg_no_interlock),
        .cycle_now        (cycle_now),
        .issue_valid      (issue_valid),
        .issue_op         (issue_op),
        .issue_rs         (issue_rs),
        .issue_rt         (issue_rt),
        .rd_req           (rd_req),
        .rd_sel_hi        (rd_sel_hi),
        .rd_dest          (rd_dest),
        .stall            (stall),
        .wr_en            (wr_en),
        .wr_dest          (wr_dest),
        .wr_data          (wr_data)
    );

    int          n_checks = 0;
    int          n_fail   = 0;
    int          cyc      = 0;
    bit          done     = 0;
    bit          cfg      = 0;
    logic [31:0] tnow     = '0;
    logic [31:0] m_hi     = '0;
    logic [31:0] m_lo     = '0;
    logic [31:0] m_busy   = '0;

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Latency from the count of significant bits.
    function automatic int ref_lat(bit [1:0] op, bit [31:0] rs);
        bit [31:0] x;
        int        bits;
        if (op[1]) return 37;
        x = (op == 2'd0) ? (rs ^ 32'($signed(rs) >>> 21)) : rs;
        bits = 1;
        for (int i = 0; i < 32; i++) if (x[i]) bits = i + 1;
        if (bits >= 22) return 15;
        if (bits >= 11) return 11;
        return 7;
    endfunction

    task automatic ref_result(input bit [1:0] op, input bit [31:0] rs, input bit [31:0] rt,
                              output logic [31:0] hi, output logic [31:0] lo);
        longint    ps;
        bit [63:0] pu;
        int        a;
        int        b;
        case (op)
            2'd0: begin
                ps = longint'($signed(rs)) * longint'($signed(rt));
                hi = ps[63:32];
                lo = ps[31:0];
            end
            2'd1: begin
                pu = 64'(rs) * 64'(rt);
                hi = pu[63:32];
                lo = pu[31:0];
            end
            2'd2: begin
                if (rt == 0) begin
                    hi = rs;
                    lo = rs[31] ? 32'd1 : 32'hFFFF_FFFF;
                end else if (rs == 32'h8000_0000 && rt == 32'hFFFF_FFFF) begin
                    hi = 32'd0;
                    lo = 32'h8000_0000;
                end else begin
                    a  = $signed(rs);
                    b  = $signed(rt);
                    lo = a / b;
                    hi = a % b;
                end
            end
            default: begin
                if (rt == 0) begin
                    hi = rs;
                    lo = 32'hFFFF_FFFF;
                end else begin
                    lo = rs / rt;
                    hi = rs % rt;
                end
            end
        endcase
    endtask

    // One clock: drive, compare against the model, then advance the model.
    task automatic step(input string tag, input bit iv, input bit [1:0] op,
                        input bit [31:0] rs, input bit [31:0] rt,
                        input bit rq, input bit sh, input bit [4:0] dst,
                        output bit st);
        bit          e_stall;
        bit          e_wen;
        logic [31:0] left;
        logic [31:0] nhi;
        logic [31:0] nlo;
        @(negedge clk);
        cfg_no_interlock = cfg;
        cycle_now        = tnow;
        issue_valid      = iv;
        issue_op         = op;
        issue_rs         = rs;
        issue_rt         = rt;
        rd_req           = rq;
        rd_sel_hi        = sh;
        rd_dest          = dst;
        #1;
        left    = m_busy - tnow;
        e_stall = rq && !cfg && left != 0 && left <= 37;
        e_wen   = rq && !e_stall && dst != 0;
        check(tag, "stall", 32'(stall), 32'(e_stall));
        check(tag, "wr_en", 32'(wr_en), 32'(e_wen));
        if (e_wen) begin
            check(tag, "wr_data", wr_data, sh ? m_hi : m_lo);
            check(tag, "wr_dest", 32'(wr_dest), 32'(dst));
        end
        st = stall;
        @(posedge clk);
        if (iv) begin
            ref_result(op, rs, rt, nhi, nlo);
            m_hi = nhi;
            m_lo = nlo;
            if (!cfg) m_busy = tnow + 32'(ref_lat(op, rs));
        end
        tnow = tnow + 1;
    endtask

    task automatic idle(input string tag);
        bit st;
        step(tag, 0, 2'd0, 0, 0, 0, 0, 5'd0, st);
    endtask

    task automatic read_reg(input string tag, input bit sh, input bit [4:0] dst);
        bit st;
        step(tag, 0, 2'd0, 0, 0, 1, sh, dst, st);
    endtask

    task automatic issue(input string tag, input bit [1:0] op,
                         input bit [31:0] rs, input bit [31:0] rt);
        bit st;
        step(tag, 1, op, rs, rt, 0, 0, 5'd0, st);
    endtask

    // Issue, then hold a HI read until it completes; count stalled cycles.
    task automatic measure(input string tag, input bit [1:0] op,
                           input bit [31:0] rs, input bit [31:0] rt, input int exp_lat);
        bit st;
        int stalls = 0;
        issue(tag, op, rs, rt);
        for (int k = 0; k < 60; k++) begin
            step(tag, 0, 2'd0, 0, 0, 1, 1, 5'd2, st);
            if (!st) break;
            stalls++;
        end
        check(tag, "stall cycle count", 32'(stalls), 32'(exp_lat - 1));
        read_reg(tag, 0, 5'd3);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual %0d cycles expected below 20000", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        bit st;
        rst = 1'b1;
        cfg_no_interlock = 1'b0;
        cycle_now = '0;
        issue_valid = 1'b0;
        issue_op = 2'd0;
        issue_rs = '0;
        issue_rt = '0;
        rd_req = 1'b0;
        rd_sel_hi = 1'b0;
        rd_dest = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R13: reset contents, stamp 0 does not stall at counter 0.
        read_reg("R13", 0, 5'd1);
        read_reg("R13", 1, 5'd1);

        // R1 / R7: unsigned multiply results and latency bands.
        measure("R1", 2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 15);
        measure("R1", 2'd1, 32'h0001_2345, 32'h0000_0100, 11);
        measure("R7", 2'd1, 32'h0000_03FF, 32'h3, 7);
        measure("R7", 2'd1, 32'h0000_07FF, 32'h5, 11);
        measure("R7", 2'd1, 32'h001F_FFFF, 32'h7, 11);
        measure("R7", 2'd1, 32'h0020_0000, 32'h9, 15);
        measure("R7", 2'd1, 32'h0000_0000, 32'h1234, 7);

        // R2 / R8: signed multiply results and latency on the sign-folded value.
        measure("R2", 2'd0, 32'hFFFF_FFFD, 32'h0000_0007, 7);
        measure("R2", 2'd0, 32'h8000_0000, 32'h8000_0000, 15);
        measure("R8", 2'd0, 32'hFFFF_FFFF, 32'h0000_0002, 7);
        measure("R8", 2'd0, 32'h0010_0000, 32'hFFFF_FFFF, 11);
        measure("R8", 2'd0, 32'hFFE0_0000, 32'h0000_0003, 11);
        measure("R8", 2'd0, 32'h4000_0000, 32'h0000_0003, 15);
        measure("R8", 2'd0, 32'hFFFF_FC00, 32'h0000_0005, 7);

        // R3 / R9: divide results and fixed latency.
        measure("R3", 2'd3, 32'd100, 32'd7, 37);
        measure("R3", 2'd2, 32'hFFFF_FF9C, 32'd7, 37);
        measure("R3", 2'd2, 32'd100, 32'hFFFF_FFF9, 37);
        measure("R9", 2'd2, 32'hFFFF_FF9C, 32'hFFFF_FFF9, 37);

        // R4: zero divisors.
        measure("R4", 2'd3, 32'd5, 32'd0, 37);
        measure("R4", 2'd2, 32'hFFFF_FFFB, 32'd0, 37);
        measure("R4", 2'd2, 32'd5, 32'd0, 37);

        // R5: the overflowing signed divide.
        measure("R5", 2'd2, 32'h8000_0000, 32'hFFFF_FFFF, 37);

        // R12 / R6: interlock off, result readable the next cycle.
        tnow = tnow + 32'd200;
        cfg = 1;
        issue("R12", 2'd1, 32'h00FF_FFFF, 32'h0000_1000);
        read_reg("R6", 0, 5'd4);
        read_reg("R6", 1, 5'd4);
        issue("R12", 2'd3, 32'd1000, 32'd3);
        read_reg("R12", 1, 5'd5);
        cfg = 0;
        // No stamp was recorded, so the read goes through with interlock back on.
        read_reg("R12", 0, 5'd5);

        // R6: issue and read in the same cycle returns the old value.
        cfg = 1;
        step("R6", 1, 2'd1, 32'd6, 32'd7, 1, 0, 5'd6, st);
        read_reg("R6", 0, 5'd6);
        cfg = 0;

        // R10: stamp wraps past 2^32.
        tnow = 32'hFFFF_FFF0;
        measure("R10", 2'd3, 32'd77, 32'd5, 37);

        // R10: distance exactly 37 stalls, 38 proceeds.
        tnow = 32'h0000_5000;
        issue("R10", 2'd3, 32'd50, 32'd5);
        tnow = 32'h0000_5000;
        read_reg("R10", 0, 5'd7);
        tnow = 32'h0000_4FFF;
        read_reg("R10", 0, 5'd7);
        // Counter behind the stamp by far more than the window.
        tnow = 32'h0000_4F00;
        read_reg("R10", 1, 5'd7);
        // Counter past the stamp: wraps to a large distance.
        tnow = 32'h0000_6000;
        read_reg("R10", 1, 5'd7);

        // R11: destination 0 never writes, but still stalls while busy.
        read_reg("R11", 0, 5'd0);
        issue("R11", 2'd2, 32'd9, 32'd2);
        read_reg("R11", 1, 5'd0);
        read_reg("R11", 0, 5'd0);
        repeat (40) idle("R11");
        read_reg("R11", 1, 5'd0);
        read_reg("R11", 1, 5'd8);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule